// File: doc/BRIEF.md
# Embedded-sync interlaced video stream decoder

The block takes an 8-bit interlaced video byte stream at one byte per clock and recovers all of its timing from codes carried inside the data. There are no separate sync wires. Each code is the four-byte sequence 0xFF, 0x00, 0x00, followed by a status byte. The status byte tells whether the code opens or closes active video, which field the line belongs to, and whether the line lies in vertical blanking. The bytes between an opening code and the next closing code carry multiplexed luma and chroma samples. The decoder separates them and tags every luma sample with its field, its active-line index within the field and its pixel index within the line. A downstream scaler or frame writer can then place each line on the odd or even rows of a progressive frame.

The control is one state machine with four named states:

- `ST_SEEK`: after reset, waiting for the first valid end-of-active code.
- `ST_HBLANK`: between an end-of-active code and the next start-of-active code.
- `ST_ACTIVE`: inside the active part of a picture line.
- `ST_VSKIP`: inside the active part of a line that lies in vertical blanking.

The transitions are:

- `T_LOCK`: `ST_SEEK` to `ST_HBLANK` on a valid end code.
- `T_OPEN`: `ST_HBLANK` to `ST_ACTIVE` on a valid start code with V=0.
- `T_OPEN_VB`: `ST_HBLANK` to `ST_VSKIP` on a valid start code with V=1.
- `T_CLOSE`: `ST_ACTIVE` or `ST_VSKIP` to `ST_HBLANK` on a valid end code.

Every other code, and every code that fails its protection check, leaves the state unchanged.

Top module: `vid_sync_decoder`

## Requirements
- R1: A timing code is recognised when the bytes 0xFF, 0x00, 0x00 are followed by a status byte. In the status byte, bit 7 is always 1, bit 6 is F, bit 5 is V and bit 4 is H. H=0 marks start of active video and H=1 marks end of active video.
- R2: A start code is acted on only in `ST_HBLANK`, that is, after an end code. After reset, start codes and data are ignored until the first valid end code. No strobe fires outside `ST_ACTIVE`.
- R3: In an active line the bytes run Cb, Y, Cr, Y, repeating, and the phase restarts at every start code. Each luma byte appears on `y_data` with `y_valid` high for one cycle, 4 cycles after that byte is sampled. `pix_idx` counts luma samples from 0 at every start code.
- R4: On each Cr byte, `c_valid` pulses and `cb_data`/`cr_data` show the Cb/Cr pair of that sample group. `c_valid` and `y_valid` are never high in the same cycle.
- R5: The status bits 3..0 must equal V^H, F^H, F^V and F^V^H. A code that fails this check, or that has bit 7 clear, changes no state. It raises `prot_err` for one cycle, one cycle after its status byte.
- R6: `field_id` shows the F bit (0 = first field) of the current active line. `line_idx` is 0 for the first active line of a field and rises by one on each later active line.
- R7: `field_start` pulses one cycle after the first accepted V=0 start code that follows any valid code with V=1. `frame_start` pulses in that same cycle when F=0.
- R8: `len_err` becomes 1 and stays 1 until reset when an end code closes an active line whose luma count differs from `LINE_PIX`.
- R9: Lines whose start code has V=1 produce no luma or chroma strobes.
- R10: After reset all strobes, pulses, `len_err`, `field_id`, `line_idx` and `pix_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 8 | Video stream byte |
| y_data | output | 8 | Luma sample |
| y_valid | output | 1 | Luma strobe |
| cb_data | output | 8 | Blue-difference sample |
| cr_data | output | 8 | Red-difference sample |
| c_valid | output | 1 | Chroma pair strobe |
| field_id | output | 1 | Field of the current line, 0 = first |
| line_idx | output | LINE_W | Active line index within the field |
| pix_idx | output | PIX_W | Index of the luma sample on y_data |
| field_start | output | 1 | Pulse at the first active line of a field |
| frame_start | output | 1 | Pulse at the first active line of a first field |
| prot_err | output | 1 | Pulse on a rejected code |
| len_err | output | 1 | Sticky wrong-line-length flag |

## Verification
A status byte sampled at a rising edge acts through state that is registered at the following edge. So `prot_err`, `field_start`, `frame_start` and `len_err` are due one cycle after that byte. A sample byte travels through a four-stage history, and its luma or chroma strobe is due four cycles after the byte is sampled. The bench drives bytes and samples outputs on falling edges. It compares the strobes in arrival order against queues filled at send time, so the latency is absorbed without guessing cycle numbers. The one-cycle flags are read only after further bytes have been clocked in.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

    typedef enum logic [1:0] {
        ST_SEEK,
        ST_HBLANK,
        ST_ACTIVE,
        ST_VSKIP
    } vsd_state_t;

    // Status byte check: marker bit set and protection nibble consistent.
    function automatic logic status_sound(input logic [7:0] s);
        logic f, v, h;
        f = s[6];
        v = s[5];
        h = s[4];
        return s[7] && (s[3] == (v ^ h)) && (s[2] == (f ^ h)) &&
               (s[1] == (f ^ v)) && (s[0] == (f ^ v ^ h));
    endfunction

endpackage

// File: rtl/vsd_code_finder.sv
module vsd_code_finder (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] din,
    output logic       preamble,
    output logic       code_ok,
    output logic       code_bad,
    output logic       f_bit,
    output logic       v_bit,
    output logic       h_bit,
    output logic [7:0] tap
);
    import vsd_pkg::*;

    localparam int DEPTH = 4;

    logic [7:0] hist [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) hist[i] <= 8'h00;
        end else begin
            hist[0] <= din;
            for (int i = 1; i < DEPTH; i++) hist[i] <= hist[i-1];
        end
    end

    always_comb begin
        preamble = (hist[3] == 8'hFF) && (hist[2] == 8'h00) && (hist[1] == 8'h00);
        code_ok  = preamble && status_sound(hist[0]);
        code_bad = preamble && !status_sound(hist[0]);
        f_bit    = hist[0][6];
        v_bit    = hist[0][5];
        h_bit    = hist[0][4];
        tap      = hist[3];
    end

endmodule

// File: rtl/vsd_sample_split.sv
module vsd_sample_split #(
    parameter int LINE_PIX = 720,
    localparam int PIX_W = $clog2(2 * LINE_PIX + 1),
    localparam int BYTE_W = $clog2(2 * LINE_PIX + 8)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             preamble,
    input  logic             sav_take,
    input  logic             eav_active,
    input  logic [7:0]       tap,
    output logic [7:0]       y_data,
    output logic             y_valid,
    output logic [7:0]       cb_data,
    output logic [7:0]       cr_data,
    output logic             c_valid,
    output logic [PIX_W-1:0] pix_idx,
    output logic             len_err
);
    localparam logic [BYTE_W-1:0] BYTE_MAX = {BYTE_W{1'b1}};
    localparam logic [PIX_W-1:0]  PIX_MAX  = {PIX_W{1'b1}};
    localparam logic [PIX_W-1:0]  PIX_GOAL = PIX_W'(LINE_PIX);

    logic [BYTE_W-1:0] bidx;
    logic [PIX_W-1:0]  pcnt;
    logic [7:0]        cb_hold;
    logic              emit;
    logic [1:0]        phase;

    // The tap lags the stream by three bytes, so sample k of the line sits at bidx k+3.
    always_comb begin
        emit  = active && !preamble && (bidx >= BYTE_W'(3));
        phase = 2'(bidx[1:0] + 2'd1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bidx    <= '0;
            pcnt    <= '0;
            cb_hold <= 8'h00;
            y_data  <= 8'h00;
            y_valid <= 1'b0;
            cb_data <= 8'h00;
            cr_data <= 8'h00;
            c_valid <= 1'b0;
            pix_idx <= '0;
            len_err <= 1'b0;
        end else begin
            y_valid <= 1'b0;
            c_valid <= 1'b0;
            if (sav_take) begin
                bidx <= '0;
                pcnt <= '0;
            end else if (active && bidx != BYTE_MAX) begin
                bidx <= bidx + 1'b1;
            end
            if (emit) begin
                unique case (phase)
                    2'd0: cb_hold <= tap;
                    2'd2: begin
                        cr_data <= tap;
                        cb_data <= cb_hold;
                        c_valid <= 1'b1;
                    end
                    default: begin
                        y_data  <= tap;
                        y_valid <= 1'b1;
                        pix_idx <= pcnt;
                        if (pcnt != PIX_MAX) pcnt <= pcnt + 1'b1;
                    end
                endcase
            end
            if (eav_active && pcnt != PIX_GOAL) len_err <= 1'b1;
        end
    end

endmodule

// File: rtl/vsd_field_track.sv
module vsd_field_track #(
    parameter int MAX_LINES = 1024,
    localparam int LINE_W = $clog2(MAX_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_ok,
    input  logic              f_bit,
    input  logic              v_bit,
    input  logic              sav_take,
    output logic              field_id,
    output logic [LINE_W-1:0] line_idx,
    output logic              field_start,
    output logic              frame_start
);
    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

    logic in_vb;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_vb       <= 1'b0;
            field_id    <= 1'b0;
            line_idx    <= '0;
            field_start <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            field_start <= 1'b0;
            frame_start <= 1'b0;
            if (code_ok && v_bit) begin
                in_vb <= 1'b1;
            end else if (sav_take) begin
                in_vb    <= 1'b0;
                field_id <= f_bit;
                if (in_vb) begin
                    line_idx    <= '0;
                    field_start <= 1'b1;
                    frame_start <= !f_bit;
                end else if (line_idx != LINE_MAX) begin
                    line_idx <= line_idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/vid_sync_decoder.sv
module vid_sync_decoder #(
    parameter int LINE_PIX = 720,
    parameter int MAX_LINES = 1024,
    localparam int PIX_W = $clog2(2 * LINE_PIX + 1),
    localparam int LINE_W = $clog2(MAX_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        din,
    output logic [7:0]        y_data,
    output logic              y_valid,
    output logic [7:0]        cb_data,
    output logic [7:0]        cr_data,
    output logic              c_valid,
    output logic              field_id,
    output logic [LINE_W-1:0] line_idx,
    output logic [PIX_W-1:0]  pix_idx,
    output logic              field_start,
    output logic              frame_start,
    output logic              prot_err,
    output logic              len_err
);
    import vsd_pkg::*;

    vsd_state_t state, state_nx;
    logic       preamble, code_ok, code_bad, f_bit, v_bit, h_bit;
    logic [7:0] tap;
    logic       sav_take, eav_active;

    vsd_code_finder u_find (
        .clk(clk), .rst_n(rst_n), .din(din), .preamble(preamble),
        .code_ok(code_ok), .code_bad(code_bad), .f_bit(f_bit),
        .v_bit(v_bit), .h_bit(h_bit), .tap(tap)
    );

    // Next-state process
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SEEK:   if (code_ok && h_bit) state_nx = ST_HBLANK;
            ST_HBLANK: if (code_ok && !h_bit) state_nx = v_bit ? ST_VSKIP : ST_ACTIVE;
            ST_ACTIVE: if (code_ok && h_bit) state_nx = ST_HBLANK;
            ST_VSKIP:  if (code_ok && h_bit) state_nx = ST_HBLANK;
            default:   state_nx = ST_SEEK;
        endcase
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_SEEK;
        else        state <= state_nx;
    end

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) prot_err <= 1'b0;
        else        prot_err <= code_bad;
    end

    always_comb begin
        sav_take   = (state == ST_HBLANK) && code_ok && !h_bit;
        eav_active = (state == ST_ACTIVE) && code_ok && h_bit;
    end

    vsd_sample_split #(.LINE_PIX(LINE_PIX)) u_split (
        .clk(clk), .rst_n(rst_n), .active(state == ST_ACTIVE),
        .preamble(preamble), .sav_take(sav_take), .eav_active(eav_active),
        .tap(tap), .y_data(y_data), .y_valid(y_valid), .cb_data(cb_data),
        .cr_data(cr_data), .c_valid(c_valid), .pix_idx(pix_idx),
        .len_err(len_err)
    );

    vsd_field_track #(.MAX_LINES(MAX_LINES)) u_field (
        .clk(clk), .rst_n(rst_n), .code_ok(code_ok), .f_bit(f_bit),
        .v_bit(v_bit), .sav_take(sav_take), .field_id(field_id),
        .line_idx(line_idx), .field_start(field_start),
        .frame_start(frame_start)
    );

endmodule

// File: rtl/vsd_checker.sv
module vsd_checker #(
    parameter int LW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          y_valid,
    input logic          c_valid,
    input logic          field_id,
    input logic [LW-1:0] line_idx,
    input logic          field_start,
    input logic          frame_start,
    input logic          prot_err,
    input logic          len_err
);
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(y_valid && c_valid));

    p_frame_in_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (field_start && !field_id));

    p_line_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |-> (line_idx == '0));

    p_len_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |=> len_err);

    p_bad_code_inert_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> !field_start);

endmodule

bind vid_sync_decoder vsd_checker #(.LW(LINE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .y_valid(y_valid), .c_valid(c_valid),
    .field_id(field_id), .line_idx(line_idx), .field_start(field_start),
    .frame_start(frame_start), .prot_err(prot_err), .len_err(len_err)
);

// File: tb/tb_vid_sync_decoder.sv
`timescale 1ns/1ps
module tb_vid_sync_decoder;
    localparam int LP = 8;
    localparam int ML = 64;
    localparam int PW = $clog2(2 * LP + 1);
    localparam int LW = $clog2(ML);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] din = 8'h10;
    logic [7:0] y_data, cb_data, cr_data;
    logic y_valid, c_valid, field_id, field_start, frame_start, prot_err, len_err;
    logic [LW-1:0] line_idx;
    logic [PW-1:0] pix_idx;

    int n_chk = 0, n_fail = 0;
    int n_y = 0, n_c = 0, n_fs = 0, n_frm = 0, n_perr = 0;
    bit done = 0;
    int ey[$], ep[$], el[$], ef[$], ecb[$], ecr[$];

    vid_sync_decoder #(.LINE_PIX(LP), .MAX_LINES(ML)) dut (
        .clk(clk), .rst_n(rst_n), .din(din), .y_data(y_data), .y_valid(y_valid),
        .cb_data(cb_data), .cr_data(cr_data), .c_valid(c_valid),
        .field_id(field_id), .line_idx(line_idx), .pix_idx(pix_idx),
        .field_start(field_start), .frame_start(frame_start),
        .prot_err(prot_err), .len_err(len_err)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ramp(input bit f, input int l, input int p);
        return 8'(32 + 17 * l + 3 * p + 80 * int'(f));
    endfunction

    // Monitor: strobes are compared in order against send-time expectations.
    always @(negedge clk) begin
        if (rst_n) begin
            if (y_valid) begin
                n_y++;
                if (ey.size() == 0) chk(0, "R2/R9 unexpected luma", int'(y_data), -1);
                else begin
                    chk(int'(y_data) == ey[0], "R3 luma value", int'(y_data), ey[0]);
                    chk(int'(pix_idx) == ep[0], "R3 pixel index", int'(pix_idx), ep[0]);
                    chk(int'(line_idx) == el[0], "R6 line index", int'(line_idx), el[0]);
                    chk(int'(field_id) == ef[0], "R6 field flag", int'(field_id), ef[0]);
                    void'(ey.pop_front()); void'(ep.pop_front());
                    void'(el.pop_front()); void'(ef.pop_front());
                end
            end
            if (c_valid) begin
                n_c++;
                if (ecb.size() == 0) chk(0, "R4/R9 unexpected chroma", int'(cb_data), -1);
                else begin
                    chk(int'(cb_data) == ecb[0], "R4 Cb value", int'(cb_data), ecb[0]);
                    chk(int'(cr_data) == ecr[0], "R4 Cr value", int'(cr_data), ecr[0]);
                    void'(ecb.pop_front()); void'(ecr.pop_front());
                end
            end
            if (field_start) n_fs++;
            if (frame_start) n_frm++;
            if (prot_err) n_perr++;
        end
    end

    task automatic put(input logic [7:0] b);
        din = b;
        @(negedge clk);
    endtask

    task automatic send_code(input bit f, input bit v, input bit h);
        put(8'hFF); put(8'h00); put(8'h00);
        put({1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h});
    endtask

    task automatic blank(input int n);
        for (int i = 0; i < n; i++) put(i[0] ? 8'h10 : 8'h80);
    endtask

    task automatic payload(input bit f, input bit v, input int l, input int nluma);
        for (int q = 0; q < nluma / 2; q++) begin
            if (v) begin
                put(8'h80); put(8'h10); put(8'h80); put(8'h10);
            end else begin
                ecb.push_back(8'h40 + q); ecr.push_back(8'hC0 + q);
                for (int k = 0; k < 2; k++) begin
                    ey.push_back(int'(ramp(f, l, 2 * q + k)));
                    ep.push_back(2 * q + k); el.push_back(l); ef.push_back(int'(f));
                end
                put(8'(8'h40 + q)); put(ramp(f, l, 2 * q));
                put(8'(8'hC0 + q)); put(ramp(f, l, 2 * q + 1));
            end
        end
    endtask

    task automatic send_line(input bit f, input bit v, input int l, input int nluma);
        send_code(f, v, 1'b1);
        blank(4);
        send_code(f, v, 1'b0);
        payload(f, v, l, nluma);
    endtask

    task automatic t_reset;
        chk(y_valid == 0 && c_valid == 0, "R10 strobes idle", int'(y_valid), 0);
        chk(field_start == 0 && frame_start == 0, "R10 pulses idle", int'(field_start), 0);
        chk(len_err == 0 && prot_err == 0, "R10 error flags clear", int'(len_err), 0);
        chk(field_id == 0 && line_idx == 0 && pix_idx == 0, "R10 counters zero",
            int'(line_idx), 0);
    endtask

    task automatic t_seek_order;
        send_code(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 2 * LP; i++) put(8'h55);
        blank(8);
        chk(n_y == 0 && n_c == 0, "R2 start code ignored before first end code", n_y, 0);
    endtask

    task automatic t_two_fields;
        int fs0 = n_fs, fr0 = n_frm, y0 = n_y, c0 = n_c;
        for (int f = 0; f < 2; f++) begin
            for (int i = 0; i < 2; i++) send_line(f[0], 1'b1, 0, LP);
            for (int l = 0; l < 3; l++) send_line(f[0], 1'b0, l, LP);
        end
        send_code(1'b1, 1'b1, 1'b1);
        blank(8);
        chk(n_fs - fs0 == 2, "R7 one field start per field", n_fs - fs0, 2);
        chk(n_frm - fr0 == 1, "R7 frame start only on first field", n_frm - fr0, 1);
        chk(n_y - y0 == 6 * LP, "R1/R9 luma count over two fields", n_y - y0, 6 * LP);
        chk(n_c - c0 == 3 * LP, "R4 chroma pair count", n_c - c0, 3 * LP);
        chk(ey.size() == 0, "R3 all expected luma seen", ey.size(), 0);
        chk(len_err == 0, "R8 no length error on full lines", int'(len_err), 0);
        chk(n_perr == 0, "R5 no false code rejection", n_perr, 0);
    endtask

    task automatic t_bad_prot;
        int p0 = n_perr, y0 = n_y, fs0 = n_fs, fr0 = n_frm;
        send_code(1'b0, 1'b0, 1'b1);
        blank(4);
        put(8'hFF); put(8'h00); put(8'h00); put(8'h81);
        for (int i = 0; i < 2 * LP; i++) put(8'h66);
        blank(4);
        chk(n_perr - p0 == 1, "R5 corrupted code flagged", n_perr - p0, 1);
        chk(n_y == y0, "R5 corrupted start code opens no line", n_y - y0, 0);
        chk(n_fs == fs0, "R5 corrupted code starts no field", n_fs - fs0, 0);
        send_line(1'b0, 1'b0, 0, LP);
        send_code(1'b0, 1'b0, 1'b1);
        blank(8);
        chk(n_y - y0 == LP, "R5 next valid line decoded", n_y - y0, LP);
        chk(n_frm - fr0 == 1, "R7 frame start after blanking", n_frm - fr0, 1);
    endtask

    task automatic t_short_line;
        chk(len_err == 0, "R8 flag clear before short line", int'(len_err), 0);
        send_line(1'b0, 1'b0, 1, LP - 2);
        send_code(1'b0, 1'b0, 1'b1);
        blank(4);
        chk(len_err == 1, "R8 short line flagged", int'(len_err), 1);
        send_line(1'b0, 1'b0, 2, LP);
        send_code(1'b0, 1'b0, 1'b1);
        blank(8);
        chk(len_err == 1, "R8 flag sticky", int'(len_err), 1);
        chk(ey.size() == 0, "R3 pixel index restarts per line", ey.size(), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_seek_order;
        t_two_fields;
        t_bad_prot;
        t_short_line;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            chk(0, "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule